// File: doc/BRIEF.md
# Row Edge Byte-Mask Generator

This block turns a pair of byte addresses, the first and the last address of a row segment, into the partial-store enable mask for the first 8-byte word of that segment. Each mask bit stands for one element of the word; elements can be bytes, halfwords or words, and the bit order within the mask can follow either byte ordering. When both addresses fall in the same 8-byte block, the mask is narrowed further so that it also stops at the end address. A store unit uses the mask to write only the pixels that belong to the segment.

As a side product, the block can also produce integer condition codes for the subtraction of the end address from the start address. The 32-bit flag set comes from the low halves and the 64-bit flag set comes from the full addresses. A loop can then test whether the segment is finished without a separate compare. A mode input for 32-bit addressing limits the block comparison to the low halves of the addresses. Every operation presented with `in_valid` produces its results one clock later.

Top module: `edge_mask_gen`

## Requirements
- R1: Only `opf[3:0]` is decoded and `opf[8:4]` has no effect. `opf[3:2]` selects the element size: 0 is byte, 1 is halfword, 2 is word, and 3 behaves as byte. `opf[1]`=1 selects little-endian ordering. `opf[0]`=1 suppresses the condition-code update.
- R2: For the byte size, with i=`addr_a[2:0]` and j=`addr_b[2:0]`, the mask is 8 bits wide. Big-endian left sets bits 7-i down to 0 and big-endian right sets bits 7 down to 7-j. Little-endian left sets bits 7 down to i and little-endian right sets bits j down to 0.
- R3: For the halfword size, i=`addr_a[2:1]` and j=`addr_b[2:1]` index a 4-lane mask in `mask_out[3:0]`, using the same lane rules as R2 with 4 lanes. `mask_out[7:4]` is 0.
- R4: For the word size, i=`addr_a[2]` and j=`addr_b[2]` index a 2-lane mask in `mask_out[1:0]`, using the same lane rules with 2 lanes. `mask_out[7:2]` is 0.
- R5: If `addr_a[63:3]` equals `addr_b[63:3]`, the result is left AND right. Otherwise the result is the left mask alone. An empty mask is possible when the two addresses are in the same block and the right lane lies before the left lane.
- R6: When `narrow_mode`=1, bits 63:32 of both addresses are treated as zero for the block comparison of R5.
- R7: When condition codes are updated, `xcc_out` and `icc_out` hold N (bit 3), Z (bit 2), V (bit 1) and C (bit 0) of `addr_a - addr_b`. `xcc_out` is computed over 64 bits and `icc_out` over bits 31:0. Both always use the unmodified addresses, whatever the value of `narrow_mode`.
- R8: `cc_we` is 1 exactly on result cycles of operations with `opf[0]`=0. Operations with `opf[0]`=1 return `icc_out`=`xcc_out`=0.
- R9: Results appear one clock after `in_valid`, and `out_valid` mirrors `in_valid` delayed by one cycle. Reset clears `out_valid`, `cc_we`, `mask_out`, `icc_out` and `xcc_out`.
- R10: In cycles without `in_valid`, `mask_out`, `icc_out` and `xcc_out` keep their last values, and `cc_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| addr_a | input | 64 | Segment start address |
| addr_b | input | 64 | Segment end address |
| opf | input | 9 | Operation variant code |
| narrow_mode | input | 1 | 32-bit addressing mode |
| out_valid | output | 1 | Result registers hold a new result |
| mask_out | output | 8 | Edge enable mask |
| icc_out | output | 4 | 32-bit flags N,Z,V,C |
| xcc_out | output | 4 | 64-bit flags N,Z,V,C |
| cc_we | output | 1 | Condition-code write enable |

## Verification
The hardest case to reach is two addresses that share an 8-byte block, and the case where they share it only once the upper halves are cleared in 32-bit addressing mode. Independent random 64-bit addresses almost never produce either. The random stimulus therefore builds the end address from the start address, sometimes keeping every bit above bit 2 and sometimes flipping only upper-half bits. Directed sweeps cover every lane pair of every size and ordering, both inside one block and across a block boundary. Directed cases also force signed overflow separately in the 32-bit and 64-bit flags.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } elem_size_e;

    typedef struct packed {
        elem_size_e size;
        logic       little;
        logic       no_cc;
    } edge_op_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

endpackage

// File: rtl/edge_op_decode.sv
module edge_op_decode
    import edge_mask_pkg::*;
#(
    parameter int OPF_W = 9
) (
    input  logic [OPF_W-1:0] opf,
    output edge_op_t         op
);
    logic unused_opf_hi;

    assign unused_opf_hi = ^opf[OPF_W-1:4];

    always_comb begin
        op.size   = elem_size_e'(opf[3:2]);
        op.little = opf[1];
        op.no_cc  = opf[0];
    end
endmodule

// File: rtl/edge_lane_masks.sv
module edge_lane_masks
    import edge_mask_pkg::*;
#(
    parameter int MASK_W = 8,
    parameter int OFF_W  = $clog2(MASK_W)
) (
    input  logic [OFF_W-1:0]  off_a,
    input  logic [OFF_W-1:0]  off_b,
    input  elem_size_e        size,
    input  logic              little,
    output logic [MASK_W-1:0] left_m,
    output logic [MASK_W-1:0] right_m
);
    localparam int NSIZE = 3;

    for (genvar s = 0; s < NSIZE; s++) begin : g_size
        localparam int              LANES = MASK_W >> s;
        localparam logic [MASK_W-1:0] FULL = {MASK_W{1'b1}} >> (MASK_W - LANES);
        int                ia;
        int                ib;
        logic [MASK_W-1:0] lm;
        logic [MASK_W-1:0] rm;

        always_comb begin
            ia = int'(off_a) >> s;
            ib = int'(off_b) >> s;
            if (little) begin
                lm = (FULL << ia) & FULL;
                rm = FULL >> (LANES - 1 - ib);
            end else begin
                lm = FULL >> ia;
                rm = (FULL << (LANES - 1 - ib)) & FULL;
            end
        end
    end

    always_comb begin
        unique case (size)
            SZ_HALF: begin
                left_m  = g_size[1].lm;
                right_m = g_size[1].rm;
            end
            SZ_WORD: begin
                left_m  = g_size[2].lm;
                right_m = g_size[2].rm;
            end
            default: begin
                left_m  = g_size[0].lm;
                right_m = g_size[0].rm;
            end
        endcase
    end
endmodule

// File: rtl/edge_sub_flags.sv
module edge_sub_flags
    import edge_mask_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output cc_flags_t    flags
);
    logic [W-1:0] diff;

    always_comb begin
        diff    = lhs - rhs;
        flags.n = diff[W-1];
        flags.z = (diff == '0);
        flags.v = (lhs[W-1] ^ rhs[W-1]) & (lhs[W-1] ^ diff[W-1]);
        flags.c = (lhs < rhs);
    end
endmodule

// File: rtl/edge_mask_gen.sv
module edge_mask_gen
    import edge_mask_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32,
    parameter int MASK_W   = 8,
    parameter int OPF_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [OPF_W-1:0]  opf,
    input  logic              narrow_mode,
    output logic              out_valid,
    output logic [MASK_W-1:0] mask_out,
    output logic [3:0]        icc_out,
    output logic [3:0]        xcc_out,
    output logic              cc_we
);
    localparam int OFF_W = $clog2(MASK_W);
    localparam logic [ADDR_W-1:0] LOW_KEEP =
        {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic              valid;
        logic [MASK_W-1:0] mask;
        cc_flags_t         icc;
        cc_flags_t         xcc;
        logic              cc_we;
    } res_state_t;

    edge_op_t          op;
    logic [MASK_W-1:0] left_m;
    logic [MASK_W-1:0] right_m;
    cc_flags_t         flags_w;
    cc_flags_t         flags_n;
    logic [ADDR_W-1:0] cmp_a;
    logic [ADDR_W-1:0] cmp_b;
    logic              same_blk;
    res_state_t        st_d;
    res_state_t        st_q;

    edge_op_decode #(.OPF_W(OPF_W)) u_dec (
        .opf (opf),
        .op  (op)
    );

    edge_lane_masks #(.MASK_W(MASK_W), .OFF_W(OFF_W)) u_lanes (
        .off_a   (addr_a[OFF_W-1:0]),
        .off_b   (addr_b[OFF_W-1:0]),
        .size    (op.size),
        .little  (op.little),
        .left_m  (left_m),
        .right_m (right_m)
    );

    edge_sub_flags #(.W(ADDR_W)) u_flags_wide (
        .lhs   (addr_a),
        .rhs   (addr_b),
        .flags (flags_w)
    );

    edge_sub_flags #(.W(NARROW_W)) u_flags_narrow (
        .lhs   (addr_a[NARROW_W-1:0]),
        .rhs   (addr_b[NARROW_W-1:0]),
        .flags (flags_n)
    );

    always_comb begin
        cmp_a    = narrow_mode ? (addr_a & LOW_KEEP) : addr_a;
        cmp_b    = narrow_mode ? (addr_b & LOW_KEEP) : addr_b;
        same_blk = (cmp_a[ADDR_W-1:OFF_W] == cmp_b[ADDR_W-1:OFF_W]);

        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.cc_we = in_valid & ~op.no_cc;
        if (in_valid) begin
            st_d.mask = same_blk ? (left_m & right_m) : left_m;
            st_d.icc  = op.no_cc ? '0 : flags_n;
            st_d.xcc  = op.no_cc ? '0 : flags_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign mask_out  = st_q.mask;
    assign icc_out   = st_q.icc;
    assign xcc_out   = st_q.xcc;
    assign cc_we     = st_q.cc_we;

    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r8_we_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> out_valid);
    a_r8_we_update: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !opf[0]) |=> cc_we);
    a_r8_we_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opf[0]) |=> (!cc_we && icc_out == 4'h0 && xcc_out == 4'h0));
    a_r3_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opf[3:2] == 2'b01) |=> (mask_out[MASK_W-1:MASK_W/2] == '0));
    a_r4_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opf[3:2] == 2'b10) |=> (mask_out[MASK_W-1:MASK_W/4] == '0));
    a_r7_equal_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !opf[0] && addr_a == addr_b) |=> (icc_out[2] && xcc_out[2]));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(mask_out) && $stable(icc_out) && $stable(xcc_out)));
endmodule

// File: tb/edge_mask_gen_test.sv
module edge_mask_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic [8:0]  opf = '0;
    logic        narrow = 1'b0;
    logic        out_valid;
    logic [7:0]  mask_out;
    logic [3:0]  icc_out;
    logic [3:0]  xcc_out;
    logic        cc_we;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] last_mask;
    logic [3:0] last_icc;
    logic [3:0] last_xcc;

    always #2 clk = ~clk;

    edge_mask_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .addr_a      (a),
        .addr_b      (b),
        .opf         (opf),
        .narrow_mode (narrow),
        .out_valid   (out_valid),
        .mask_out    (mask_out),
        .icc_out     (icc_out),
        .xcc_out     (xcc_out),
        .cc_we       (cc_we)
    );

    // R2 R3 R4 R5 R6: lane-by-lane model
    function automatic logic [7:0] ref_mask(input logic [63:0] x, input logic [63:0] y,
                                           input logic [8:0] code, input logic nm);
        int sz;
        int lanes;
        int i;
        int j;
        logic big;
        logic same;
        logic [7:0] lm;
        logic [7:0] rm;
        sz = int'(code[3:2]);
        if (sz == 3) sz = 0;
        lanes = 8 >> sz;
        i = int'(x[2:0]) >> sz;
        j = int'(y[2:0]) >> sz;
        big = !code[1];
        lm = '0;
        rm = '0;
        for (int k = 0; k < lanes; k++) begin
            lm[k] = big ? (k <= lanes - 1 - i) : (k >= i);
            rm[k] = big ? (k >= lanes - 1 - j) : (k <= j);
        end
        same = nm ? (x[31:3] == y[31:3]) : (x[63:3] == y[63:3]);
        return same ? (lm & rm) : lm;
    endfunction

    // R7: flags from a 65-bit signed difference
    function automatic logic [3:0] ref_flags(input logic [63:0] x, input logic [63:0] y);
        logic signed [64:0] sd;
        logic [63:0] d;
        sd = $signed({x[63], x}) - $signed({y[63], y});
        d = sd[63:0];
        return {d[63], (d == 64'd0), (sd[64] != sd[63]), (x < y)};
    endfunction

    function automatic string size_tag(input logic [8:0] code);
        case (code[3:2])
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [63:0] ta, input logic [63:0] tb,
                         input logic [8:0] tc, input logic tn, input string ctx);
        logic [7:0] em;
        logic [3:0] ei;
        logic [3:0] ex;
        a = ta;
        b = tb;
        opf = tc;
        narrow = tn;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        em = ref_mask(ta, tb, tc, tn);
        ei = tc[0] ? 4'h0 : ref_flags(ta << 32, tb << 32);
        ex = tc[0] ? 4'h0 : ref_flags(ta, tb);
        chk({"R9 out_valid ", ctx}, 64'(out_valid), 64'd1);
        chk({size_tag(tc), "/R5 mask ", ctx}, 64'(mask_out), 64'(em));
        chk({"R8 cc_we ", ctx}, 64'(cc_we), 64'(!tc[0]));
        chk({"R7/R8 icc ", ctx}, 64'(icc_out), 64'(ei));
        chk({"R7/R8 xcc ", ctx}, 64'(xcc_out), 64'(ex));
        last_mask = em;
        last_icc = ei;
        last_xcc = ex;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [63:0] ra;
        logic [63:0] rb;
        int pick;
        void'($urandom(32'd4242));

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 reset out_valid", 64'(out_valid), 64'd0);
        chk("R9 reset cc_we", 64'(cc_we), 64'd0);
        chk("R9 reset mask", 64'(mask_out), 64'd0);
        chk("R9 reset icc", 64'(icc_out), 64'd0);
        chk("R9 reset xcc", 64'(xcc_out), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5: every lane pair, same block and next block
        for (int c = 0; c < 12; c++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    issue(64'h1000 + 64'(i), 64'h1000 + 64'(j), 9'(c), 1'b0, "sweep same");
                    issue(64'h1000 + 64'(i), 64'h1008 + 64'(j), 9'(c), 1'b0, "sweep next");
                end
            end
        end

        // R5: empty mask when right lane precedes left lane in one block
        issue(64'h2006, 64'h2001, 9'h000, 1'b0, "R5 empty");
        chk("R5 empty mask value", 64'(mask_out), 64'h00);

        // R1: upper opf bits ignored, size code 3 as byte
        issue(64'h3003, 64'h3005, 9'h1f4, 1'b0, "R1 upper bits");
        chk("R1 half via upper bits", 64'(mask_out), 64'h06);
        issue(64'h3003, 64'h3005, 9'h00e, 1'b0, "R1 reserved size");
        chk("R1 reserved as byte little", 64'(mask_out), 64'h38);

        // R6: upper halves differ, low halves share a block
        issue(64'h0000_0001_0000_0012, 64'h0000_0002_0000_0015, 9'h000, 1'b1, "R6 narrow");
        chk("R6 narrow anded mask", 64'(mask_out), 64'h3c);
        issue(64'h0000_0001_0000_0012, 64'h0000_0002_0000_0015, 9'h000, 1'b0, "R6 wide");
        chk("R6 wide left only", 64'(mask_out), 64'h3f);
        chk("R7 flags use full addresses", 64'(xcc_out), 64'h9);

        // R7: overflow in 64-bit flags, then in 32-bit flags
        issue(64'h8000_0000_0000_0000, 64'h1, 9'h000, 1'b0, "R7 xcc ovf");
        chk("R7 xcc V set", 64'(xcc_out[1]), 64'd1);
        issue(64'h0000_0000_8000_0000, 64'h1, 9'h008, 1'b0, "R7 icc ovf");
        chk("R7 icc V set", 64'(icc_out[1]), 64'd1);
        chk("R7 xcc V clear", 64'(xcc_out[1]), 64'd0);
        issue(64'h55, 64'h55, 9'h004, 1'b0, "R7 equal");

        // R10: idle cycles hold results
        issue(64'h4001, 64'h7fff, 9'h002, 1'b0, "R10 setup");
        for (int k = 0; k < 3; k++) begin
            a = 64'(k) * 64'h1111;
            b = 64'hffff;
            opf = 9'h000;
            @(negedge clk);
            chk("R10 idle out_valid", 64'(out_valid), 64'd0);
            chk("R10 idle cc_we", 64'(cc_we), 64'd0);
            chk("R10 idle mask held", 64'(mask_out), 64'(last_mask));
            chk("R10 idle icc held", 64'(icc_out), 64'(last_icc));
            chk("R10 idle xcc held", 64'(xcc_out), 64'(last_xcc));
        end

        // random mix with related addresses
        for (int n = 0; n < 3000; n++) begin
            ra = {$urandom, $urandom};
            pick = int'($urandom % 4);
            case (pick)
                0: rb = {$urandom, $urandom};
                1: rb = {ra[63:3], 3'($urandom)};
                2: rb = {ra[63:32] ^ $urandom, ra[31:3], 3'($urandom)};
                default: rb = ra;
            endcase
            issue(ra, rb, 9'($urandom), 1'($urandom), "random");
        end

        finish_run();
    end
endmodule